// File: doc/BRIEF.md
# Fractional clock enable divider

This block paces a small sequencer from the system clock. Instead of making a new clock, it raises a single-cycle advance pulse, `step_o`. Each pulse lets the sequencer take exactly one step. The pulse rate is set by a fixed-point divisor with a 16-bit integer part and an 8-bit fractional part.

The integer part sets the base period in system clocks. An 8-bit accumulator gathers the fraction once per period. Whenever that accumulator overflows, the period being loaded is one clock longer. Over time the average spacing between pulses equals the divisor, so a divisor of 2.5 gives gaps of 2, 3, 2, 3 and so on. Slowing the sequencer in this way stretches every step by the same amount and never changes what the sequencer does.

An enable input freezes the divider. A restart strobe puts the divider back to its starting phase, so that several dividers loaded with the same divisor and restarted together stay aligned.

Top module: `frac_step_div`

## Requirements
- R1: After reset, `step_o` is low while `en_i` is low. The first cycle with `en_i` high and `restart_i` low has `step_o` high.
- R2: With an integer divisor N (N ≥ 2, fraction 0), consecutive pulses are exactly N cycles apart.
- R3: With divisor D = I + F/256, the gap after the k-th pulse (counting from 0 after a restart) is floor((k+1)·D) − floor(k·D). For example, 2.5 gives gaps 2, 3, 2, 3.
- R4: The fraction is summed in an 8-bit accumulator, once per period. A period is one cycle longer exactly when that sum carries out of bit 7. For example, 3 + 64/256 gives gaps 3, 3, 3, 4.
- R5: Integer part 1 with fraction 0 keeps `step_o` high on every enabled cycle.
- R6: Integer part 0 with fraction 0 means a divisor of 65536, so pulses are 65536 cycles apart.
- R7: Integer part 0 with a non-zero fraction is clamped to 1.0, so `step_o` is high on every enabled cycle.
- R8: `restart_i` clears both the counter and the accumulator. The next enabled cycle pulses, and the gaps that follow begin again at k = 0 of R3.
- R9: While `en_i` is low, `step_o` stays low and the remaining count and the accumulator are held. Once `en_i` returns, the interrupted period finishes with its remaining count.
- R10: `step_o` is low in any cycle where `restart_i` is high.
- R11: The divisor is sampled only when a period is loaded, which is the cycle of a pulse. A change made in the middle of a period takes effect from the next period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| div_int_i | input | 16 | Integer part of the divisor |
| div_frac_i | input | 8 | Fractional part of the divisor, in units of 1/256 |
| en_i | input | 1 | Run enable; when low, the divider holds its state |
| restart_i | input | 1 | Synchronous strobe that clears the counter and the accumulator |
| step_o | output | 1 | Single-cycle advance pulse |

## Verification
The bench measures the gaps between pulses over several periods and compares them with the floor formula.

- If the accumulator carry were ignored, every gap would equal the integer part.
- If the carry were applied one period late, the long and short periods would swap places, for example 3, 2 instead of 2, 3 for a divisor of 2.5.
- The code 0 corner cases are checked: a design that failed to widen to 65536 would pulse every cycle or never. A design that failed to clamp would pulse with the wrong spacing.
- The bench restarts while the accumulator holds a non-zero value, pauses partway through a period, and changes the divisor in the middle of a period. These tests expose a restart that leaves stale phase behind, a pause that loses or reloads the count, and a divisor that is applied before the period reload.

// File: rtl/fsd_pkg.sv
package fsd_pkg;
  // how the raw divisor was interpreted
  typedef enum logic [1:0] {
    DM_PLAIN = 2'd0,
    DM_WRAP  = 2'd1,  // integer 0 -> full range
    DM_CLAMP = 2'd2   // integer 0 with fraction -> 1.0
  } div_mode_e;
endpackage

// File: rtl/fsd_decode.sv
module fsd_decode
  import fsd_pkg::*;
#(
  parameter int INT_W  = 16,
  parameter int FRAC_W = 8,
  localparam int CNT_W = INT_W + 1
) (
  input  logic [INT_W-1:0]  div_int_i,
  input  logic [FRAC_W-1:0] div_frac_i,
  output logic [CNT_W-1:0]  int_eff_o,
  output logic [FRAC_W-1:0] frac_eff_o,
  output div_mode_e         mode_o
);
  always_comb begin
    if (div_int_i != '0) mode_o = DM_PLAIN;
    else if (div_frac_i == '0) mode_o = DM_WRAP;
    else mode_o = DM_CLAMP;
  end

  always_comb begin
    unique case (mode_o)
      DM_WRAP: begin
        int_eff_o  = {1'b1, {INT_W{1'b0}}};
        frac_eff_o = '0;
      end
      DM_CLAMP: begin
        int_eff_o  = CNT_W'(1);
        frac_eff_o = '0;
      end
      default: begin
        int_eff_o  = {1'b0, div_int_i};
        frac_eff_o = div_frac_i;
      end
    endcase
  end

  // R7: a clamped divisor carries no fraction
  always_comb begin
    a_r7_clamp_no_frac: assert (!(mode_o == DM_CLAMP) || (frac_eff_o == '0 && int_eff_o == CNT_W'(1)));
  end
endmodule

// File: rtl/fsd_accum.sv
module fsd_accum #(
  parameter int FRAC_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              load_i,
  input  logic [FRAC_W-1:0] frac_i,
  output logic              carry_o
);
  logic [FRAC_W-1:0] acc_q;
  logic [FRAC_W:0]   sum;

  assign sum     = {1'b0, acc_q} + {1'b0, frac_i};
  assign carry_o = sum[FRAC_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      acc_q <= '0;
    else if (clear_i) acc_q <= '0;
    else if (load_i)  acc_q <= sum[FRAC_W-1:0];
  end

  // R8: restart leaves a zero accumulator
  a_r8_acc_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> acc_q == '0);
  // R9: no period load, no accumulator change
  a_r9_acc_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && !load_i) |=> $stable(acc_q));
endmodule

// File: rtl/fsd_counter.sv
module fsd_counter #(
  parameter int INT_W = 16,
  localparam int CNT_W = INT_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             run_i,
  input  logic [CNT_W-1:0] int_eff_i,
  input  logic             carry_i,
  output logic             zero_o
);
  localparam logic [CNT_W-1:0] MAX_CNT = {1'b1, {INT_W{1'b0}}};

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] reload;

  // remaining cycles after this pulse, lengthened by the carry
  assign reload = int_eff_i - CNT_W'(1) + {{INT_W{1'b0}}, carry_i};
  assign zero_o = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (run_i) begin
      if (zero_o) cnt_q <= reload;
      else        cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  // R6: count never exceeds the full-range period
  a_r6_cnt_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= MAX_CNT);
  // R9: held while stopped
  a_r9_cnt_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && !run_i) |=> $stable(cnt_q));
  // R2: a running count steps down by one
  a_r2_cnt_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && run_i && cnt_q != '0) |=> cnt_q == $past(cnt_q) - CNT_W'(1));
  // R8: restart returns to phase zero
  a_r8_cnt_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> cnt_q == '0);
endmodule

// File: rtl/frac_step_div.sv
module frac_step_div
  import fsd_pkg::*;
#(
  parameter int INT_W  = 16,
  parameter int FRAC_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [INT_W-1:0]  div_int_i,
  input  logic [FRAC_W-1:0] div_frac_i,
  input  logic              en_i,
  input  logic              restart_i,
  output logic              step_o
);
  localparam int CNT_W = INT_W + 1;

  logic [CNT_W-1:0]  int_eff;
  logic [FRAC_W-1:0] frac_eff;
  div_mode_e         mode;
  logic              carry;
  logic              zero;
  logic              run;

  assign run    = en_i && !restart_i;
  assign step_o = run && zero;

  fsd_decode #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_decode (
    .div_int_i (div_int_i),
    .div_frac_i(div_frac_i),
    .int_eff_o (int_eff),
    .frac_eff_o(frac_eff),
    .mode_o    (mode)
  );

  fsd_accum #(.FRAC_W(FRAC_W)) u_accum (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(restart_i),
    .load_i (step_o),
    .frac_i (frac_eff),
    .carry_o(carry)
  );

  fsd_counter #(.INT_W(INT_W)) u_counter (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (restart_i),
    .run_i    (run),
    .int_eff_i(int_eff),
    .carry_i  (carry),
    .zero_o   (zero)
  );

  // R10: no pulse under restart
  a_r10_restart_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |-> !step_o);
  // R9: no pulse while disabled
  a_r9_no_step_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> !step_o);
  // R8: first enabled cycle after restart pulses
  a_r8_restart_phase: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (restart_i ##1 (en_i && !restart_i)) |-> step_o);
  // R5/R7: unity divisor pulses on back-to-back cycles
  a_r5_unity: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_o && (mode == DM_CLAMP || (div_int_i == INT_W'(1) && div_frac_i == '0)))
      ##1 (en_i && !restart_i) |-> step_o);
endmodule

// File: tb/sim_frac_step_div.sv
module sim_frac_step_div;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] div_int = 16'd1;
  logic [7:0]  div_frac = 8'd0;
  logic        en = 1'b0;
  logic        restart = 1'b0;
  logic        step;

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;
  int st[32];
  int n_st = 0;

  always #4 clk = ~clk;

  frac_step_div u0 (
    .clk_i(clk), .rst_ni(rst_n), .div_int_i(div_int), .div_frac_i(div_frac),
    .en_i(en), .restart_i(restart), .step_o(step)
  );

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // sample each cycle at negedge+1, record pulse cycles
  task automatic run_cycles(int n);
    for (int i = 0; i < n; i++) begin
      #1;
      if (step && n_st < 32) begin
        st[n_st] = cyc;
        n_st++;
      end
      cyc++;
      @(negedge clk);
    end
  endtask

  task automatic clr_log();
    n_st = 0;
    cyc = 0;
  endtask

  function automatic int exp_gap(int i_part, int f_part, int k);
    int f;
    f = i_part * 256 + f_part;
    return ((k + 1) * f) / 256 - (k * f) / 256;
  endfunction

  task automatic do_restart();
    restart = 1'b1;
    run_cycles(1);
    restart = 1'b0;
    clr_log();
  endtask

  localparam int NV = 8;
  localparam logic [23:0] VEC [NV] = '{
    {16'd2, 8'd0}, {16'd5, 8'd0}, {16'd2, 8'd128}, {16'd3, 8'd64},
    {16'd5, 8'd3}, {16'd7, 8'd255}, {16'd4, 8'd192}, {16'd1, 8'd128}
  };

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    n_err++;
    n_chk++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin : main
    @(negedge clk);
    #1 chk("R1 step in reset", int'(step), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    clr_log();
    run_cycles(3);
    chk("R1 idle after reset", n_st, 0);
    en = 1'b1;
    clr_log();
    run_cycles(1);
    chk("R1 first enabled cycle", n_st, 1);

    // table walk: gaps over 8 periods
    for (int v = 0; v < NV; v++) begin
      div_int = VEC[v][23:8];
      div_frac = VEC[v][7:0];
      do_restart();
      run_cycles(9 * 8 + 2);
      chk("R3 pulse count", (n_st >= 9) ? 1 : 0, 1);
      for (int k = 0; k < 8; k++) begin
        if (n_st > k + 1)
          chk((div_frac == 0) ? "R2 gap" : "R3 R4 gap", st[k + 1] - st[k],
              exp_gap(int'(div_int), int'(div_frac), k));
      end
    end

    // R4: 3.25 gives 3,3,3,4
    div_int = 16'd3; div_frac = 8'd64;
    do_restart();
    run_cycles(14);
    chk("R4 long period", st[4] - st[3], 4);
    chk("R4 short period", st[1] - st[0], 3);

    // R5: unity
    div_int = 16'd1; div_frac = 8'd0;
    do_restart();
    run_cycles(10);
    chk("R5 every cycle", n_st, 10);

    // R7: clamp
    div_int = 16'd0; div_frac = 8'd5;
    do_restart();
    run_cycles(10);
    chk("R7 clamp every cycle", n_st, 10);

    // R6: full range
    div_int = 16'd0; div_frac = 8'd0;
    do_restart();
    run_cycles(65540);
    chk("R6 pulses in window", n_st, 2);
    chk("R6 gap", st[1] - st[0], 65536);

    // R8 + R10: restart with accumulator at 128
    div_int = 16'd2; div_frac = 8'd128;
    do_restart();
    run_cycles(1);
    restart = 1'b1;
    #1 chk("R10 no pulse in restart", int'(step), 0);
    run_cycles(1);
    restart = 1'b0;
    clr_log();
    run_cycles(8);
    chk("R8 pulse after restart", st[0], 0);
    chk("R8 first gap", st[1] - st[0], 2);
    chk("R8 second gap", st[2] - st[1], 3);

    // R9: pause mid period, divisor 4
    div_int = 16'd4; div_frac = 8'd0;
    do_restart();
    run_cycles(2);
    en = 1'b0;
    clr_log();
    run_cycles(6);
    chk("R9 no pulse while off", n_st, 0);
    en = 1'b1;
    clr_log();
    run_cycles(4);
    chk("R9 resume count", n_st, 1);
    chk("R9 resume position", st[0], 2);

    // R11: change divisor mid period
    div_int = 16'd3; div_frac = 8'd0;
    do_restart();
    run_cycles(1);
    div_int = 16'd6;
    run_cycles(12);
    chk("R11 old period kept", st[1], 3);
    chk("R11 new period", st[2] - st[1], 6);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule